// File: doc/BRIEF.md
# Translation Cache with Range Purge

This block is a small fully associative cache of address translations. Each slot holds a valid flag, a 3-bit region tag, a page base in a 61-bit virtual space and a page-size code giving the page size as a power of two in bytes. Software fills slots by index and probes the cache with a full 64-bit address. A probe returns whether a slot maps that address, which slot it is, and its page size.

The purge command takes a 64-bit address operand and a size operand. Every valid slot whose page shares any byte with the purge window is invalidated. Both the purge window and the pages are naturally aligned powers of two, so a purge can be smaller than a page, equal to it, or cover many pages. The purge runs as a sequential sweep that checks one slot per cycle. While the sweep runs, the block drops its ready output and ignores all requests. A one-cycle done pulse marks the end of the sweep.

Top module: `xlat_purge_cache`

## Requirements
- R1: After a synchronous reset every slot is invalid, `ready` is 1, and `pg_done` and `lk_done` are 0.
- R2: An accepted insert writes slot `ins_slot`. The region tag comes from `ins_addr[63:61]`. The size code is `ins_psz` clamped into [PS_MIN, PS_MAX], with defaults 12 and 28. The base is `ins_addr[60:0]` with the bits below the clamped size cleared. The slot becomes valid.
- R3: One cycle after an accepted probe, `lk_done` is 1 for one cycle. A slot matches when it is valid, its region tag equals `lk_addr[63:61]`, and its base equals `lk_addr[60:0]` above its size code. `lk_hit` reports the lowest matching slot in `lk_slot` and that slot's code in `lk_psz`. On a miss `lk_slot` and `lk_psz` are 0. These outputs hold until the next accepted probe.
- R4: For a purge, the region tag comes from `pg_addr[63:61]`, the address from `pg_addr[60:0]`, and the window size code from `pg_size[7:2]`, so the window is 2^code bytes aligned down to that size.
- R5: A purge invalidates every valid slot that has the same region tag and whose page overlaps the window, whether the overlap is partial or complete. Slots with another region tag, or with no overlap, stay valid.
- R6: A purge size code below PS_MIN is treated as PS_MIN.
- R7: A purge size code above PS_MAX invalidates every slot.
- R8: An accepted purge start drops `ready` for exactly the number of slots (16 cycles by default), one slot per cycle. `pg_done` is then high for one cycle, in the same cycle `ready` returns to 1.
- R9: While `ready` is 0, inserts, probes and purge starts are ignored. No slot is written, no probe completes, and the running sweep is not restarted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_en | input | 1 | Insert request |
| ins_slot | input | 4 | Slot index to write |
| ins_addr | input | 64 | Region tag and page address for the insert |
| ins_psz | input | 6 | Page-size code for the insert |
| lk_en | input | 1 | Probe request |
| lk_addr | input | 64 | Region tag and address to probe |
| lk_done | output | 1 | Probe result valid pulse |
| lk_hit | output | 1 | Probe found a matching slot |
| lk_slot | output | 4 | Lowest matching slot |
| lk_psz | output | 6 | Size code of the matching slot |
| pg_start | input | 1 | Purge start request |
| pg_addr | input | 64 | Purge region tag and address |
| pg_size | input | 64 | Purge size operand, code in bits 7:2 |
| ready | output | 1 | Block idle; requests are accepted |
| pg_done | output | 1 | One-cycle pulse at the end of a purge |

## Verification
The purge is tried with a window the same size as a page, one smaller than and inside a large page, and one larger than a page. A window in the right place but under another region tag shows that the tag comparison is applied. A purge at a code below the minimum shows that clamping keeps the purge from becoming a flush, and a code above the maximum shows a full flush. Probes between purges observe each slot through the normal interface. They include duplicate pages in two slots, which checks the lowest-slot priority and that both copies are removed. Requests issued during a sweep check the stall. A behavioural model compares every output on every clock.

// File: rtl/xlat_purge_pkg.sv
package xlat_purge_pkg;
  localparam int ADDR_W = 64;
  localparam int RID_W  = 3;
  localparam int VA_W   = 61;
  localparam int PSZ_W  = 6;

  // bit i set when i lies at or above the page-size code
  function automatic logic [VA_W-1:0] hi_mask(input logic [PSZ_W-1:0] ps);
    logic [VA_W-1:0] m;
    for (int i = 0; i < VA_W; i++) m[i] = (i >= int'(ps));
    return m;
  endfunction
endpackage

// File: rtl/xpc_overlap.sv
module xpc_overlap
  import xlat_purge_pkg::*;
(
  input  logic [RID_W-1:0] e_rid,
  input  logic [VA_W-1:0]  e_va,
  input  logic [PSZ_W-1:0] e_ps,
  input  logic [RID_W-1:0] p_rid,
  input  logic [VA_W-1:0]  p_va,
  input  logic [PSZ_W-1:0] p_ps,
  input  logic             flush,
  output logic             hit
);
  logic [PSZ_W-1:0] span;
  always_comb begin
    // aligned power-of-two ranges overlap iff they agree above the larger size
    span = (e_ps > p_ps) ? e_ps : p_ps;
    hit  = flush | ((e_rid == p_rid) && (((e_va ^ p_va) & hi_mask(span)) == '0));
  end
endmodule

// File: rtl/xpc_lookup.sv
module xpc_lookup
  import xlat_purge_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0]            valid,
  input  logic [N_ENT-1:0][RID_W-1:0] ent_rid,
  input  logic [N_ENT-1:0][VA_W-1:0]  ent_va,
  input  logic [N_ENT-1:0][PSZ_W-1:0] ent_ps,
  input  logic [ADDR_W-1:0]           q_addr,
  output logic                        hit,
  output logic [IDX_W-1:0]            slot,
  output logic [PSZ_W-1:0]            psz
);
  logic [N_ENT-1:0] match;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match[g] = valid[g] && (ent_rid[g] == q_addr[ADDR_W-1 -: RID_W]) &&
                      (((ent_va[g] ^ q_addr[VA_W-1:0]) & hi_mask(ent_ps[g])) == '0);
  end

  always_comb begin
    hit  = 1'b0;
    slot = '0;
    psz  = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit  = 1'b1;
        slot = IDX_W'(i);
        psz  = ent_ps[i];
      end
    end
  end
endmodule

// File: rtl/xpc_sweep.sv
module xpc_sweep
  import xlat_purge_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int PS_MIN = 12,
  parameter int PS_MAX = 28,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [ADDR_W-1:0] pg_size,
  output logic              busy,
  output logic              done,
  output logic [IDX_W-1:0]  idx,
  output logic [RID_W-1:0]  p_rid,
  output logic [VA_W-1:0]   p_va,
  output logic [PSZ_W-1:0]  p_ps,
  output logic              flush
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);
  localparam logic [PSZ_W-1:0] PMIN = PSZ_W'(PS_MIN);
  localparam logic [PSZ_W-1:0] PMAX = PSZ_W'(PS_MAX);

  logic [PSZ_W-1:0] code;
  logic             unused_size_bits;
  assign code             = pg_size[7:2];
  assign unused_size_bits = ^{pg_size[ADDR_W-1:8], pg_size[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      idx   <= '0;
      p_rid <= '0;
      p_va  <= '0;
      p_ps  <= '0;
      flush <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          idx   <= '0;
          p_rid <= pg_addr[ADDR_W-1 -: RID_W];
          p_va  <= pg_addr[VA_W-1:0];
          p_ps  <= (code < PMIN) ? PMIN : code;
          flush <= (code > PMAX);
        end
      end else begin
        idx <= idx + 1'b1;
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && $past(idx) == LAST));
  assert_sweep_steps_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));
endmodule

// File: rtl/xlat_purge_cache.sv
module xlat_purge_cache
  import xlat_purge_pkg::*;
#(
  parameter int N_ENT  = 16,
  parameter int PS_MIN = 12,
  parameter int PS_MAX = 28,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_en,
  input  logic [IDX_W-1:0]  ins_slot,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [PSZ_W-1:0]  ins_psz,
  input  logic              lk_en,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_slot,
  output logic [PSZ_W-1:0]  lk_psz,
  input  logic              pg_start,
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [ADDR_W-1:0] pg_size,
  output logic              ready,
  output logic              pg_done
);
  localparam logic [PSZ_W-1:0] PMIN = PSZ_W'(PS_MIN);
  localparam logic [PSZ_W-1:0] PMAX = PSZ_W'(PS_MAX);

  logic [N_ENT-1:0]            valid_q;
  logic [N_ENT-1:0][RID_W-1:0] ent_rid;
  logic [N_ENT-1:0][VA_W-1:0]  ent_va;
  logic [N_ENT-1:0][PSZ_W-1:0] ent_ps;

  logic             busy, flush;
  logic [IDX_W-1:0] idx;
  logic [RID_W-1:0] p_rid;
  logic [VA_W-1:0]  p_va;
  logic [PSZ_W-1:0] p_ps;
  logic             ov_hit;
  logic             ins_go, lk_go;
  logic [PSZ_W-1:0] ins_ps_c;
  logic             q_hit;
  logic [IDX_W-1:0] q_slot;
  logic [PSZ_W-1:0] q_psz;

  assign ready  = ~busy;
  assign ins_go = ins_en & ~busy;
  assign lk_go  = lk_en & ~busy;

  always_comb begin
    if (ins_psz < PMIN)      ins_ps_c = PMIN;
    else if (ins_psz > PMAX) ins_ps_c = PMAX;
    else                     ins_ps_c = ins_psz;
  end

  xpc_sweep #(.N_ENT(N_ENT), .PS_MIN(PS_MIN), .PS_MAX(PS_MAX)) u_sweep (
    .clk(clk), .rst(rst), .start(pg_start), .pg_addr(pg_addr), .pg_size(pg_size),
    .busy(busy), .done(pg_done), .idx(idx), .p_rid(p_rid), .p_va(p_va),
    .p_ps(p_ps), .flush(flush)
  );

  xpc_overlap u_ovl (
    .e_rid(ent_rid[idx]), .e_va(ent_va[idx]), .e_ps(ent_ps[idx]),
    .p_rid(p_rid), .p_va(p_va), .p_ps(p_ps), .flush(flush), .hit(ov_hit)
  );

  xpc_lookup #(.N_ENT(N_ENT)) u_lk (
    .valid(valid_q), .ent_rid(ent_rid), .ent_va(ent_va), .ent_ps(ent_ps),
    .q_addr(lk_addr), .hit(q_hit), .slot(q_slot), .psz(q_psz)
  );

  // slot contents: no reset, written only on insert
  always_ff @(posedge clk) begin
    if (ins_go) begin
      ent_rid[ins_slot] <= ins_addr[ADDR_W-1 -: RID_W];
      ent_va[ins_slot]  <= ins_addr[VA_W-1:0] & hi_mask(ins_ps_c);
      ent_ps[ins_slot]  <= ins_ps_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (busy) begin
      if (ov_hit) valid_q[idx] <= 1'b0;
    end else if (ins_go) begin
      valid_q[ins_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_done <= 1'b0;
      lk_hit  <= 1'b0;
      lk_slot <= '0;
      lk_psz  <= '0;
    end else begin
      lk_done <= lk_go;
      if (lk_go) begin
        lk_hit  <= q_hit;
        lk_slot <= q_slot;
        lk_psz  <= q_psz;
      end
    end
  end

  assert_probe_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (lk_en && ready) |=> lk_done);
  assert_probe_stalled_R9: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !lk_done);
  assert_no_fill_in_sweep_R9: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ((valid_q & ~$past(valid_q)) == '0));
  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && flush) |=> !valid_q[$past(idx)]);
  assert_valid_sizes_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_done && lk_hit) |-> (lk_psz >= PMIN && lk_psz <= PMAX));
endmodule

// File: tb/tb_xlat_purge_cache.sv
module tb_xlat_purge_cache;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_en = 1'b0;
  logic [3:0]  ins_slot = '0;
  logic [63:0] ins_addr = '0;
  logic [5:0]  ins_psz = '0;
  logic        lk_en = 1'b0;
  logic [63:0] lk_addr = '0;
  logic        pg_start = 1'b0;
  logic [63:0] pg_addr = '0;
  logic [63:0] pg_size = '0;
  logic        lk_done, lk_hit, ready, pg_done;
  logic [3:0]  lk_slot;
  logic [5:0]  lk_psz;

  always #10 clk = ~clk;

  xlat_purge_cache dut (
    .clk(clk), .rst(rst), .ins_en(ins_en), .ins_slot(ins_slot), .ins_addr(ins_addr),
    .ins_psz(ins_psz), .lk_en(lk_en), .lk_addr(lk_addr), .lk_done(lk_done),
    .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_psz(lk_psz), .pg_start(pg_start),
    .pg_addr(pg_addr), .pg_size(pg_size), .ready(ready), .pg_done(pg_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string phase = "R1";

  // behavioural reference
  bit          m_v[N];
  int          m_rid[N];
  logic [63:0] m_va[N];
  int          m_ps[N];
  bit          m_busy, m_done, m_lkd, m_hit;
  int          m_idx, m_slot, m_psz;
  int          m_prid, m_pps;
  logic [63:0] m_pva;
  bit          m_flush;

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic model_edge();
    if (rst) begin
      for (int s = 0; s < N; s++) m_v[s] = 0;
      m_busy = 0; m_done = 0; m_lkd = 0; m_hit = 0; m_slot = 0; m_psz = 0; m_idx = 0;
      return;
    end
    m_done = 0;
    m_lkd = 0;
    if (m_busy) begin
      int mx;
      mx = (m_ps[m_idx] > m_pps) ? m_ps[m_idx] : m_pps;
      if (m_flush || (m_rid[m_idx] == m_prid && (m_va[m_idx] >> mx) == (m_pva >> mx)))
        m_v[m_idx] = 0;
      if (m_idx == N - 1) begin m_busy = 0; m_done = 1; end
      m_idx++;
    end else begin
      if (lk_en) begin
        logic [63:0] a;
        a = {3'b0, lk_addr[60:0]};
        m_lkd = 1; m_hit = 0; m_slot = 0; m_psz = 0;
        for (int s = N - 1; s >= 0; s--)
          if (m_v[s] && m_rid[s] == int'(lk_addr[63:61]) && (m_va[s] >> m_ps[s]) == (a >> m_ps[s])) begin
            m_hit = 1; m_slot = s; m_psz = m_ps[s];
          end
      end
      if (ins_en) begin
        int p;
        p = clampi(int'(ins_psz), 12, 28);
        m_v[ins_slot] = 1;
        m_rid[ins_slot] = int'(ins_addr[63:61]);
        m_ps[ins_slot] = p;
        m_va[ins_slot] = ({3'b0, ins_addr[60:0]} >> p) << p;
      end
      if (pg_start) begin
        int c;
        c = int'(pg_size[7:2]);
        m_busy = 1; m_idx = 0;
        m_prid = int'(pg_addr[63:61]);
        m_pva = {3'b0, pg_addr[60:0]};
        m_flush = (c > 28);
        m_pps = (c < 12) ? 12 : c;
      end
    end
  endtask

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check(phase, "ready (R8)", ready, !m_busy);
    check(phase, "pg_done (R8)", pg_done, m_done);
    check(phase, "lk_done (R3)", lk_done, m_lkd);
    check(phase, "lk_hit (R3)", lk_hit, m_hit);
    check(phase, "lk_slot (R3)", lk_slot, m_slot);
    check(phase, "lk_psz (R3)", lk_psz, m_psz);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    ins_en = 0; lk_en = 0; pg_start = 0;
  endtask

  task automatic do_ins(int slot, logic [63:0] addr, int ps);
    ins_en = 1; ins_slot = 4'(slot); ins_addr = addr; ins_psz = 6'(ps);
    step();
  endtask

  task automatic probe(logic [63:0] addr, bit exp_hit, int exp_slot, string tag);
    lk_en = 1; lk_addr = addr;
    step();
    check(tag, "probe hit", lk_hit, exp_hit);
    if (exp_hit) check(tag, "probe slot", lk_slot, exp_slot);
  endtask

  task automatic purge(logic [63:0] addr, int code);
    int cyc;
    pg_start = 1; pg_addr = addr; pg_size = 64'(code) << 2;
    step();
    cyc = 0;
    while (!pg_done && cyc < 40) begin step(); cyc++; end
    check(phase, "sweep length R8", cyc, N);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    phase = "R1";
    step(); step();
    rst = 0;
    step();
    check("R1", "ready after reset", ready, 1);
    check("R1", "pg_done after reset", pg_done, 0);
    probe(64'h2000_0000_1234_5000, 0, 0, "R1");

    phase = "R2";
    do_ins(0, 64'h2000_0000_1234_5abc, 12);
    do_ins(1, 64'h2000_0000_4012_3456, 22);
    do_ins(2, 64'h4000_0000_1234_5000, 12);
    do_ins(3, 64'h2000_0000_0077_7000, 8);
    do_ins(4, 64'h2000_0000_8000_0000, 40);
    do_ins(5, 64'h2000_0000_1234_5000, 12);
    phase = "R3";
    probe(64'h2000_0000_1234_5ff0, 1, 0, "R3");
    check("R2", "aligned size", lk_psz, 12);
    probe(64'h6000_0000_1234_5000, 0, 0, "R3");
    probe(64'h2000_0000_403f_fff8, 1, 1, "R3");
    probe(64'h2000_0000_0077_7fff, 1, 3, "R2");
    check("R2", "raised size", lk_psz, 12);
    probe(64'h2000_0000_8fff_0000, 1, 4, "R2");
    check("R2", "capped size", lk_psz, 28);

    phase = "R5";
    purge(64'h2000_0000_1234_5800, 12);
    probe(64'h2000_0000_1234_5000, 0, 0, "R5");
    probe(64'h4000_0000_1234_5000, 1, 2, "R4");
    purge(64'h2000_0000_4020_0000, 12);
    probe(64'h2000_0000_4000_0000, 0, 0, "R5");
    do_ins(1, 64'h2000_0000_4000_0000, 22);
    purge(64'h2000_0000_40f0_0000, 24);
    probe(64'h2000_0000_4000_0000, 0, 0, "R5");
    probe(64'h2000_0000_8000_0000, 1, 4, "R5");

    phase = "R6";
    purge(64'h2000_0000_0077_7800, 1);
    probe(64'h2000_0000_0077_7000, 0, 0, "R6");
    probe(64'h2000_0000_8000_0000, 1, 4, "R6");

    phase = "R9";
    pg_start = 1; pg_addr = 64'h0; pg_size = 64'(12) << 2;
    step();
    ins_en = 1; ins_slot = 4'd9; ins_addr = 64'h2000_0000_0001_0000; ins_psz = 6'd12;
    step();
    lk_en = 1; lk_addr = 64'h2000_0000_8000_0000;
    step();
    check("R9", "probe ignored while busy", lk_done, 0);
    pg_start = 1; pg_addr = 64'h2000_0000_8000_0000; pg_size = 64'(63) << 2;
    step();
    begin
      int cyc = 0;
      while (!pg_done && cyc < 40) begin step(); cyc++; end
      check("R9", "sweep not restarted", cyc, N - 3);
    end
    probe(64'h2000_0000_0001_0000, 0, 0, "R9");
    probe(64'h2000_0000_8000_0000, 1, 4, "R9");

    phase = "R7";
    do_ins(9, 64'h6000_0000_0005_0000, 12);
    purge(64'h0000_0000_0000_0000, 40);
    probe(64'h2000_0000_8000_0000, 0, 0, "R7");
    probe(64'h4000_0000_1234_5000, 0, 0, "R7");
    probe(64'h6000_0000_0005_0000, 0, 0, "R7");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule